// File: doc/BRIEF.md
# Mode-Controlled GPIO Data Port

This block is the data side of a nine-pin general-purpose I/O port. It holds one stored data bit per pin. Software reaches these bits through a 16-bit register word on a simple strobe bus. Each pin gets a 2-bit mode field from outside the block. The mode field decides whether the pin is driven from its stored bit, and whether a register read returns that stored bit or the pin's sampled level.

Writes always update the stored bits, whatever the modes are. Only pins in output mode have their output enable raised. Pin levels pass through a synchronizer before the read multiplexer, and read data is registered. There are two resets. The cold (power-on) reset clears everything. The warm reset clears only the read and synchronizer state, so the stored data survives it. Low-power entry needs no action from the block, because the stored bits hold while no write strobe arrives.

Top module: `gpio_mode_port`

## Requirements
- R1: While `por_n` is low, the stored data, `pin_out` and `rdata` are all zero.
- R2: A warm reset (`warm_n` low) leaves the stored data and `pin_out` unchanged. The stored data also holds in every cycle without `wr_en`. A warm reset does clear `rdata` to zero.
- R3: Bits 15 to 9 of `rdata` are always zero, and bits 15 to 9 of `wdata` have no effect.
- R4: Mode code 2'b00 (input): the pin's output enable is low, and a read returns the synchronized pin level in the pin's bit position.
- R5: Mode code 2'b01 (output): the pin's output enable is high, and a read returns the stored bit.
- R6: Mode code 2'b11 (other function): the pin is not driven, and a read returns the synchronized pin level.
- R7: Mode code 2'b10 (reserved) behaves exactly like input mode: the pin is not driven, and a read returns the pin level.
- R8: A write stores `wdata[8:0]` (pin n in bit n) in every mode. `pin_out` shows the new value from the clock edge that samples `wr_en`.
- R9: `rdata` is loaded on the clock edge that samples `rd_en`. It holds its value while `rd_en` is low.
- R10: A pin level change reaches read data only through two flops. A read strobe sampled one edge after the pin changes returns the old level. A read strobe sampled two edges after the change returns the new level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Cold (power-on) reset, active low, asynchronous |
| warm_n | input | 1 | Warm reset, active low, asynchronous; stored data is kept |
| wr_en | input | 1 | Write strobe for the data register |
| rd_en | input | 1 | Read strobe for the data register |
| wdata | input | 16 | Write data, pin n in bit n |
| rdata | output | 16 | Registered read data, valid the cycle after `rd_en` |
| pin_mode | input | 18 | Mode field for each pin, pin n in bits 2n+1:2n |
| pin_in | input | 9 | Asynchronous pin levels |
| pin_out | output | 9 | Stored data bits presented to the pin drivers |
| pin_oe | output | 9 | Per-pin output enable |

## Verification
Several properties are checked on every cycle. The stored bits, and therefore `pin_out`, take the written value one edge after a write and hold otherwise, including through a warm reset. The reserved upper read bits stay zero. Read data holds without a strobe. Every driven pin reads back its `pin_out` value. The behaviours that depend on sampled pin levels can only be shown by the bench's scenarios: the input, reserved and other-function read paths, and the two-flop latency. The same goes for the cold and warm reset sequences and the mixed-mode read multiplexing.

// File: rtl/gpio_mode_pkg.sv
package gpio_mode_pkg;

   typedef enum logic [1:0] {
      PM_INPUT = 2'b00,
      PM_DRIVE = 2'b01,
      PM_RESVD = 2'b10,
      PM_ALTFN = 2'b11
   } pin_mode_e;

   // Only the drive code turns the pin around; reserved falls back to input.
   function automatic logic mode_drives(input logic [1:0] code);
      return pin_mode_e'(code) == PM_DRIVE;
   endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int WIDTH  = 9,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_in,
   output logic [WIDTH-1:0] sync_out
);
   logic [WIDTH-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= async_in;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
         end
      end
   end

   assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/gpio_data_reg.sv
module gpio_data_reg #(
   parameter int PIN_CNT = 9
) (
   input  logic               clk,
   input  logic               por_n,
   input  logic               wr_en,
   input  logic [PIN_CNT-1:0] wr_bits,
   output logic [PIN_CNT-1:0] store_q
);
   // Cleared only by the cold reset; warm reset and idle cycles keep it.
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)     store_q <= '0;
      else if (wr_en) store_q <= wr_bits;
   end
endmodule

// File: rtl/gpio_pin_ctrl.sv
module gpio_pin_ctrl
   import gpio_mode_pkg::*;
#(
   parameter int PIN_CNT = 9
) (
   input  logic [2*PIN_CNT-1:0] pin_mode,
   input  logic [PIN_CNT-1:0]   store_q,
   input  logic [PIN_CNT-1:0]   level_sync,
   output logic [PIN_CNT-1:0]   drive_en,
   output logic [PIN_CNT-1:0]   rd_bits
);
   for (genvar p = 0; p < PIN_CNT; p++) begin : g_pin
      logic [1:0] code;
      assign code        = pin_mode[2*p +: 2];
      assign drive_en[p] = mode_drives(code);
      assign rd_bits[p]  = drive_en[p] ? store_q[p] : level_sync[p];
   end
endmodule

// File: rtl/gpio_mode_port.sv
module gpio_mode_port #(
   parameter int PIN_CNT     = 9,
   parameter int BUS_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 por_n,
   input  logic                 warm_n,
   input  logic                 wr_en,
   input  logic                 rd_en,
   input  logic [BUS_W-1:0]     wdata,
   output logic [BUS_W-1:0]     rdata,
   input  logic [2*PIN_CNT-1:0] pin_mode,
   input  logic [PIN_CNT-1:0]   pin_in,
   output logic [PIN_CNT-1:0]   pin_out,
   output logic [PIN_CNT-1:0]   pin_oe
);
   localparam int PAD_W = BUS_W - PIN_CNT;

   if (PIN_CNT < 1 || PIN_CNT > BUS_W) begin : g_bad_width
      $error("gpio_mode_port: PIN_CNT must be 1..BUS_W");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("gpio_mode_port: SYNC_STAGES must be at least 2");
   end

   logic               sys_rst_n;
   logic [PIN_CNT-1:0] store_q;
   logic [PIN_CNT-1:0] level_sync;
   logic [PIN_CNT-1:0] rd_bits;
   logic [BUS_W-1:0]   rd_word;

   assign sys_rst_n = por_n & warm_n;

   gpio_data_reg #(.PIN_CNT(PIN_CNT)) u_store (
      .clk     (clk),
      .por_n   (por_n),
      .wr_en   (wr_en),
      .wr_bits (wdata[PIN_CNT-1:0]),
      .store_q (store_q)
   );

   gpio_in_sync #(.WIDTH(PIN_CNT), .STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (sys_rst_n),
      .async_in (pin_in),
      .sync_out (level_sync)
   );

   gpio_pin_ctrl #(.PIN_CNT(PIN_CNT)) u_ctrl (
      .pin_mode   (pin_mode),
      .store_q    (store_q),
      .level_sync (level_sync),
      .drive_en   (pin_oe),
      .rd_bits    (rd_bits)
   );

   if (PAD_W > 0) begin : g_pad
      assign rd_word = {{PAD_W{1'b0}}, rd_bits};
   end else begin : g_nopad
      assign rd_word = rd_bits;
   end

   always_ff @(posedge clk or negedge sys_rst_n) begin
      if (!sys_rst_n)  rdata <= '0;
      else if (rd_en)  rdata <= rd_word;
   end

   assign pin_out = store_q;
endmodule

// File: rtl/gpio_mode_port_chk.sv
module gpio_mode_port_chk #(
   parameter int PIN_CNT = 9,
   parameter int BUS_W   = 16
) (
   input logic                 clk,
   input logic                 por_n,
   input logic                 warm_n,
   input logic                 wr_en,
   input logic                 rd_en,
   input logic [BUS_W-1:0]     wdata,
   input logic [BUS_W-1:0]     rdata,
   input logic [PIN_CNT-1:0]   pin_out,
   input logic [PIN_CNT-1:0]   pin_oe
);
   assert_cold_clear_R1: assert property (@(posedge clk)
      !por_n |-> (pin_out == '0 && rdata == '0));

   assert_store_hold_R2: assert property (@(posedge clk) disable iff (!por_n)
      !wr_en |=> $stable(pin_out));

   assert_upper_zero_R3: assert property (@(posedge clk) disable iff (!por_n)
      rdata[BUS_W-1:PIN_CNT] == '0);

   assert_driven_readback_R5: assert property (@(posedge clk) disable iff (!por_n || !warm_n)
      rd_en |=> ((rdata[PIN_CNT-1:0] ^ $past(pin_out)) & $past(pin_oe)) == '0);

   assert_write_lands_R8: assert property (@(posedge clk) disable iff (!por_n)
      wr_en |=> pin_out == $past(wdata[PIN_CNT-1:0]));

   assert_read_hold_R9: assert property (@(posedge clk) disable iff (!por_n || !warm_n)
      !rd_en |=> $stable(rdata));
endmodule

bind gpio_mode_port gpio_mode_port_chk #(.PIN_CNT(PIN_CNT), .BUS_W(BUS_W)) u_chk (
   .clk     (clk),
   .por_n   (por_n),
   .warm_n  (warm_n),
   .wr_en   (wr_en),
   .rd_en   (rd_en),
   .wdata   (wdata),
   .rdata   (rdata),
   .pin_out (pin_out),
   .pin_oe  (pin_oe)
);

// File: tb/sim_gpio_mode_port.sv
`timescale 1ns/1ps
module sim_gpio_mode_port;
   localparam int NP = 9;

   logic          clk = 1'b0;
   logic          por_n = 1'b0;
   logic          warm_n = 1'b1;
   logic          wr_en = 1'b0;
   logic          rd_en = 1'b0;
   logic [15:0]   wdata = '0;
   logic [15:0]   rdata;
   logic [2*NP-1:0] pin_mode = '0;
   logic [NP-1:0] pin_in = '0;
   logic [NP-1:0] pin_out;
   logic [NP-1:0] pin_oe;

   int n_chk = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   gpio_mode_port u0 (
      .clk(clk), .por_n(por_n), .warm_n(warm_n), .wr_en(wr_en), .rd_en(rd_en),
      .wdata(wdata), .rdata(rdata), .pin_mode(pin_mode), .pin_in(pin_in),
      .pin_out(pin_out), .pin_oe(pin_oe)
   );

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [2*NP-1:0] all_modes(input logic [1:0] m);
      logic [2*NP-1:0] v;
      for (int i = 0; i < NP; i++) v[2*i +: 2] = m;
      return v;
   endfunction

   function automatic logic [15:0] exp_read(input logic [2*NP-1:0] md,
                                            input logic [NP-1:0] st,
                                            input logic [NP-1:0] lv);
      logic [15:0] r = '0;
      for (int i = 0; i < NP; i++) r[i] = (md[2*i +: 2] == 2'b01) ? st[i] : lv[i];
      return r;
   endfunction

   task automatic do_write(input logic [15:0] v);
      @(negedge clk); wr_en = 1'b1; wdata = v;
      @(negedge clk); wr_en = 1'b0; wdata = '0;
   endtask

   task automatic do_read(output logic [15:0] v);
      @(negedge clk); rd_en = 1'b1;
      @(negedge clk); rd_en = 1'b0; v = rdata;
   endtask

   task automatic set_pins(input logic [NP-1:0] v);
      @(negedge clk); pin_in = v;
      repeat (3) @(negedge clk);
   endtask

   task automatic t_reset_state;
      repeat (3) @(negedge clk);
      chk("R1 pin_out in cold reset", 16'(pin_out), 16'h0);
      chk("R1 rdata in cold reset", rdata, 16'h0);
      chk("R4 oe low in input mode", 16'(pin_oe), 16'h0);
      por_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_input_mode;
      logic [15:0] r;
      pin_mode = all_modes(2'b00);
      do_write(16'h00AA);
      chk("R8 pin_out after write in input mode", 16'(pin_out), 16'h00AA);
      chk("R4 not driven", 16'(pin_oe), 16'h0);
      set_pins(9'h135);
      do_read(r);
      chk("R4 input read returns pins", r, 16'h0135);
   endtask

   task automatic t_output_mode;
      logic [15:0] r;
      pin_mode = all_modes(2'b01);
      @(negedge clk);
      chk("R5 oe high in output mode", 16'(pin_oe), 16'h01FF);
      do_read(r);
      chk("R5 output read returns stored (written in input mode, R8)", r, 16'h00AA);
      do_write(16'h0153);
      do_read(r);
      chk("R5 output read after write", r, 16'h0153);
      chk("R8 pin_out follows write", 16'(pin_out), 16'h0153);
   endtask

   task automatic t_alt_mode;
      logic [15:0] r;
      pin_mode = all_modes(2'b11);
      set_pins(9'h0C3);
      do_write(16'h003C);
      chk("R6 alt function not driven", 16'(pin_oe), 16'h0);
      do_read(r);
      chk("R6 alt read returns pins", r, 16'h00C3);
   endtask

   task automatic t_reserved_mode;
      logic [15:0] r;
      pin_mode = all_modes(2'b10);
      set_pins(9'h1E1);
      do_write(16'h001E);
      chk("R7 reserved mode not driven", 16'(pin_oe), 16'h0);
      do_read(r);
      chk("R7 reserved read returns pins", r, 16'h01E1);
   endtask

   task automatic t_mixed;
      logic [15:0] r;
      logic [2*NP-1:0] md;
      for (int i = 0; i < NP; i++) md[2*i +: 2] = 2'(i % 4);
      pin_mode = md;
      do_write(16'h0155);
      set_pins(9'h0F3);
      chk("R5 mixed oe only on output pins", 16'(pin_oe), 16'h0022);
      do_read(r);
      chk("R4 R5 R6 R7 mixed read", r, exp_read(md, 9'h155, 9'h0F3));
   endtask

   task automatic t_reserved_bits;
      logic [15:0] r;
      pin_mode = all_modes(2'b01);
      do_write(16'hFFFF);
      do_read(r);
      chk("R3 upper bits read zero", r, 16'h01FF);
      do_write(16'hFE00);
      do_read(r);
      chk("R3 upper write bits ignored", r, 16'h0000);
   endtask

   task automatic t_read_hold;
      logic [15:0] r;
      pin_mode = all_modes(2'b00);
      set_pins(9'h0A5);
      do_read(r);
      set_pins(9'h15A);
      repeat (2) @(negedge clk);
      chk("R9 rdata holds without strobe", rdata, 16'h00A5);
   endtask

   task automatic t_sync_latency;
      logic [15:0] r;
      pin_mode = all_modes(2'b00);
      set_pins(9'h000);
      @(negedge clk); pin_in = 9'h1FF;
      do_read(r);
      chk("R10 strobe one edge after change reads old", r, 16'h0000);
      set_pins(9'h000);
      @(negedge clk); pin_in = 9'h1FF;
      @(negedge clk);
      do_read(r);
      chk("R10 strobe two edges after change reads new", r, 16'h01FF);
   endtask

   task automatic t_warm_reset;
      logic [15:0] r;
      pin_mode = all_modes(2'b01);
      do_write(16'h01A5);
      do_read(r);
      @(negedge clk); warm_n = 1'b0;
      @(negedge clk);
      chk("R2 rdata cleared by warm reset", rdata, 16'h0000);
      warm_n = 1'b1;
      @(negedge clk);
      chk("R2 pin_out kept through warm reset", 16'(pin_out), 16'h01A5);
      do_read(r);
      chk("R2 stored data kept through warm reset", r, 16'h01A5);
      repeat (5) @(negedge clk);
      chk("R2 stored data held while idle", 16'(pin_out), 16'h01A5);
   endtask

   task automatic t_cold_reset;
      logic [15:0] r;
      @(negedge clk); por_n = 1'b0;
      @(negedge clk);
      chk("R1 cold reset clears pin_out", 16'(pin_out), 16'h0);
      chk("R1 cold reset clears rdata", rdata, 16'h0);
      por_n = 1'b1;
      do_read(r);
      chk("R1 stored data zero after cold reset", r, 16'h0000);
   endtask

   task automatic finish_run;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      t_reset_state();
      t_input_mode();
      t_output_mode();
      t_alt_mode();
      t_reserved_mode();
      t_mixed();
      t_reserved_bits();
      t_read_hold();
      t_sync_latency();
      t_warm_reset();
      t_cold_reset();
      finish_run();
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog (all requirements) actual=running expected=finished");
      finish_run();
   end
endmodule